// File: doc/BRIEF.md
# Serial Converter Control-Frame Port

This block is the slave side of the four-wire serial port that fronts a multichannel converter's digital core. The host opens a frame by pulling chip select low and then toggles the serial clock, which idles high. In one frame of sixteen clocks the host sends a control word on the data input while the block sends back the previous conversion result on the data output. That result leaves as a 4-bit channel tag followed by 12 data bits.

The received word is committed to a 15-bit control register only when its leading bit is 1, and only when chip select rises after exactly sixteen falling clock edges have been taken in. The register fields go straight to the rest of the core: repeat mode, eight channel enables, temperature conversion enable, external reference select, temperature averaging and partial power-down. The pins are sampled by the core clock through a synchronizer, so all state belongs to the single `clk` domain. The conversion result is supplied on input ports and captured when chip select falls.

Top module: `adc_ctrl_port`

## Requirements
- R1: After a synchronous active-low reset, every register field output is 0 and `dout_oe` is 0. A reset asserted after a write clears the fields again.
- R2: Data-input bits are taken on falling serial-clock edges, most significant bit first. In the committed word, bit 14 drives `rep_en`, bit 13 down to bit 6 drive `ch_sel[0]` up to `ch_sel[7]`, bit 5 drives `temp_en`, bit 2 drives `ext_ref_en`, bit 1 drives `temp_avg_en` and bit 0 drives `pwr_down`. Bits 4 and 3 affect no output.
- R3: A word whose bit 15 is 0 leaves every field output unchanged.
- R4: Field outputs never change while chip select is low. A complete word takes effect only after chip select rises.
- R5: A frame that ends after fewer than 16 falling edges changes no field output.
- R6: Falling edges after the 16th in a frame are ignored, so the committed word is the first 16 bits.
- R7: When chip select falls, `{res_tag, res_data}` is captured. Its most significant bit appears on `dout` before the first falling edge, and each rising edge of the serial clock moves `dout` to the next bit, so the 16 bits sampled on the falling edges equal the captured value.
- R8: `dout_oe` is 1 while chip select is low and 0 while it is high. When it is 0, the pad is released.
- R9: Once `pwr_down` is 1, it stays 1 through frames with bit 15 at 0 and through short frames. It returns to 0 only when a committed word has bit 0 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idles high |
| din | input | 1 | Serial control data from the host |
| res_tag | input | 4 | Channel tag of the result to send |
| res_data | input | 12 | Result value to send |
| dout | output | 1 | Serial result data to the host |
| dout_oe | output | 1 | Output enable for the data-out pad |
| rep_en | output | 1 | Repeat-sequence mode |
| ch_sel | output | 8 | Channel enables, index 0 is the first channel |
| temp_en | output | 1 | Temperature conversion enable |
| ext_ref_en | output | 1 | External reference select |
| temp_avg_en | output | 1 | Temperature averaging enable |
| pwr_down | output | 1 | Partial power-down |

## Verification
Any internal fault in this block ends up in one of two places at the ports. A wrong bit counter or a misaligned receive shifter shows as a wrong field value a few core clocks after chip select rises. It can also show as a commit that should not have happened, after a short or gated frame. A bad transmit load or shift shows in the very next frame, as a tag or data word that differs from the captured result. The bench reads both back frame by frame and compares them with a model of the register.

// File: rtl/acp_pkg.sv
package acp_pkg;

   // Control fields in the order of received bits 14 down to 0
   typedef struct packed {
      logic       rpt;
      logic [7:0] chan;     // chan[7] is the first channel
      logic       temp;
      logic [1:0] spare;
      logic       ext_ref;
      logic       t_avg;
      logic       pd;
   } acp_ctrl_t;

   localparam int unsigned CTRL_BITS = $bits(acp_ctrl_t);
   localparam int unsigned CHAN_BITS = 8;
   localparam acp_ctrl_t   CTRL_RESET = '0;

   function automatic acp_ctrl_t acp_unpack(input logic [CTRL_BITS-1:0] bits);
      return acp_ctrl_t'(bits);
   endfunction

endpackage

// File: rtl/acp_pin_sync.sv
module acp_pin_sync #(
   parameter int unsigned    W      = 1,
   parameter int unsigned    STAGES = 2,
   parameter logic [W-1:0]   INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin,
   output logic [W-1:0] level,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("acp_pin_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("acp_pin_sync needs a nonzero width");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];
   logic [W-1:0] prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= INIT;
         prev <= INIT;
      end else begin
         chain[0] <= pin;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
         prev <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;

endmodule

// File: rtl/acp_rx_frame.sv
module acp_rx_frame #(
   parameter int unsigned FRAME_BITS = 16,
   localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_act,
   input  logic                  cs_start,
   input  logic                  sclk_fall,
   input  logic                  din_bit,
   output logic [FRAME_BITS-1:0] word,
   output logic [CNT_W-1:0]      cnt,
   output logic                  full
);

   generate
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("acp_rx_frame needs a frame of at least two bits");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);

   assign full = (cnt == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         word <= '0;
      end else if (cs_start) begin
         cnt  <= '0;
         word <= '0;
      end else if (cs_act && sclk_fall && !full) begin
         word <= {word[FRAME_BITS-2:0], din_bit};
         cnt  <= cnt + 1'b1;
      end
   end

   AST_CNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);  // R6
   AST_EXTRA_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (full && sclk_fall && !cs_start) |=> $stable(word));  // R6

endmodule

// File: rtl/acp_tx_shift.sv
module acp_tx_shift #(
   parameter int unsigned TAG_W      = 4,
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned FRAME_BITS = 16,
   localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              cs_start,
   input  logic              sclk_rise,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [TAG_W-1:0]  tag,
   input  logic [DATA_W-1:0] data,
   output logic              dout,
   output logic              oe
);

   generate
      if (TAG_W + DATA_W != FRAME_BITS) begin : g_bad_split
         $error("acp_tx_shift: tag plus data must fill the frame");
      end
   endgenerate

   logic [FRAME_BITS-1:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh <= '0;
      end else if (cs_start) begin
         sh <= {tag, data};
      end else if (cs_act && sclk_rise && (cnt != '0)) begin
         sh <= {sh[FRAME_BITS-2:0], 1'b0};
      end
   end

   assign oe   = cs_act;
   assign dout = cs_act & sh[FRAME_BITS-1];

   AST_TAG_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_act) |=> (dout == $past(tag[TAG_W-1])));  // R7
   AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && $past(cs_act) && !$past(sclk_rise) && !$past(cs_start))
         |-> $stable(dout));  // R7

endmodule

// File: rtl/acp_ctrl_reg.sv
module acp_ctrl_reg
   import acp_pkg::*;
#(
   parameter int unsigned FRAME_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_act,
   input  logic                  cs_end,
   input  logic                  full,
   input  logic [FRAME_BITS-1:0] word,
   output acp_ctrl_t             ctrl
);

   generate
      if (FRAME_BITS != CTRL_BITS + 1) begin : g_bad_layout
         $error("acp_ctrl_reg: frame must be one gate bit plus the fields");
      end
   endgenerate

   logic gate;
   logic commit;

   assign gate   = word[FRAME_BITS-1];
   assign commit = cs_end & full & gate;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= CTRL_RESET;
      end else if (commit) begin
         ctrl <= acp_unpack(word[FRAME_BITS-2:0]);
      end
   end

   AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      cs_act |=> $stable(ctrl));  // R4
   AST_GATE_LOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && !word[FRAME_BITS-1]) |=> $stable(ctrl));  // R3
   AST_SHORT_FRAME_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_end && !full) |=> $stable(ctrl));  // R5

endmodule

// File: rtl/adc_ctrl_port.sv
module adc_ctrl_port
   import acp_pkg::*;
#(
   parameter int unsigned TAG_W       = 4,
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned FRAME_BITS = TAG_W + DATA_W,
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              din,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic [DATA_W-1:0] res_data,
   output logic              dout,
   output logic              dout_oe,
   output logic              rep_en,
   output logic [NUM_CH-1:0] ch_sel,
   output logic              temp_en,
   output logic              ext_ref_en,
   output logic              temp_avg_en,
   output logic              pwr_down
);

   generate
      if (NUM_CH != CHAN_BITS) begin : g_bad_chan
         $error("adc_ctrl_port: channel count must match the field layout");
      end
   endgenerate

   // Pin order inside the synchronizer: {cs_n, sclk, din}
   localparam int unsigned PIN_CS = 2;
   localparam int unsigned PIN_CK = 1;
   localparam int unsigned PIN_DI = 0;

   logic [2:0] pin_lvl, pin_rise, pin_fall;

   acp_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   ({cs_n, sclk, din}),
      .level (pin_lvl),
      .rise  (pin_rise),
      .fall  (pin_fall)
   );

   logic cs_act, cs_start, cs_end;
   assign cs_act   = ~pin_lvl[PIN_CS];
   assign cs_start = pin_fall[PIN_CS];
   assign cs_end   = pin_rise[PIN_CS];

   logic [FRAME_BITS-1:0] rx_word;
   logic [CNT_W-1:0]      rx_cnt;
   logic                  rx_full;

   acp_rx_frame #(.FRAME_BITS(FRAME_BITS)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .cs_start  (cs_start),
      .sclk_fall (pin_fall[PIN_CK]),
      .din_bit   (pin_lvl[PIN_DI]),
      .word      (rx_word),
      .cnt       (rx_cnt),
      .full      (rx_full)
   );

   acp_tx_shift #(.TAG_W(TAG_W), .DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .cs_start  (cs_start),
      .sclk_rise (pin_rise[PIN_CK]),
      .cnt       (rx_cnt),
      .tag       (res_tag),
      .data      (res_data),
      .dout      (dout),
      .oe        (dout_oe)
   );

   acp_ctrl_t ctrl;

   acp_ctrl_reg #(.FRAME_BITS(FRAME_BITS)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_act (cs_act),
      .cs_end (cs_end),
      .full   (rx_full),
      .word   (rx_word),
      .ctrl   (ctrl)
   );

   assign rep_en      = ctrl.rpt;
   assign temp_en     = ctrl.temp;
   assign ext_ref_en  = ctrl.ext_ref;
   assign temp_avg_en = ctrl.t_avg;
   assign pwr_down    = ctrl.pd;

   // First channel sits at the highest channel bit of the word
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
         assign ch_sel[i] = ctrl.chan[NUM_CH-1-i];
      end
   endgenerate

   AST_PD_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_down) |-> $past(rx_full && rx_word[FRAME_BITS-1] && !rx_word[0]));  // R9
   AST_FIRST_CHAN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_end && rx_full && rx_word[FRAME_BITS-1])
         |-> (ch_sel[0] == $past(rx_word[FRAME_BITS-3])));  // R2

endmodule

// File: tb/adc_ctrl_port_test.sv
module adc_ctrl_port_test;

   localparam int H = 8;  // core clocks per serial half period

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
   logic [3:0]  res_tag = '0;
   logic [11:0] res_data = '0;
   logic dout, dout_oe, rep_en, temp_en, ext_ref_en, temp_avg_en, pwr_down;
   logic [7:0] ch_sel;

   always #10 clk = ~clk;  // 50 MHz

   adc_ctrl_port uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .res_tag(res_tag), .res_data(res_data), .dout(dout), .dout_oe(dout_oe),
      .rep_en(rep_en), .ch_sel(ch_sel), .temp_en(temp_en),
      .ext_ref_en(ext_ref_en), .temp_avg_en(temp_avg_en), .pwr_down(pwr_down)
   );

   typedef struct {
      int          kind;   // 0 register, 1 captured dout word, 2 output enable
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t       sb_q[$];
   event        chk_ev;
   int          n_chk = 0;
   int          n_bad = 0;
   logic [15:0] model = '0;
   logic [15:0] cap = '0;
   bit          done = 0;

   function automatic logic [15:0] reg_view();
      logic [15:0] v = '0;
      v[14] = rep_en;
      for (int i = 0; i < 8; i++) v[13-i] = ch_sel[i];
      v[5] = temp_en;
      v[2] = ext_ref_en;
      v[1] = temp_avg_en;
      v[0] = pwr_down;
      return v;
   endfunction

   // Monitor: pops expected items and compares with what the ports show
   initial begin
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            case (it.kind)
               0:       act = reg_view();
               1:       act = cap;
               default: act = {15'b0, dout_oe};
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, act, it.exp);
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input int kind, input logic [15:0] exp, input string req);
      item_t it;
      it.kind = kind; it.exp = exp; it.req = req;
      sb_q.push_back(it);
      -> chk_ev;
      @(negedge clk);
   endtask

   task automatic frame(input logic [15:0] w, input int nedges,
                        input logic [3:0] tg, input logic [11:0] dt, input string req);
      res_tag = tg;
      res_data = dt;
      cap = '0;
      cs_n = 1'b0;
      idle(2*H);
      push(2, 16'h0001, "R8");
      for (int i = 0; i < nedges; i++) begin
         din = (i < 16) ? w[15-i] : i[0];
         idle(H);
         if (i < 16) cap[15-i] = dout;
         sclk = 1'b0;
         idle(H);
         sclk = 1'b1;
      end
      idle(2*H);
      if (nedges >= 16) push(0, model, "R4");
      cs_n = 1'b1;
      idle(2*H);
      if (nedges >= 16 && w[15]) model = w & 16'h7FE7;
      push(0, model, req);
      if (nedges >= 16) push(1, {tg, dt}, "R7");
      push(2, 16'h0000, "R8");
   endtask

   initial begin
      idle(4);
      push(0, 16'h0000, "R1");
      push(2, 16'h0000, "R1");
      rst_n = 1'b1;
      idle(4);
      push(0, 16'h0000, "R1");

      frame(16'hC0A5, 16, 4'h3, 12'hABC, "R2");
      frame(16'hBFFF, 16, 4'h9, 12'h001, "R2");
      frame(16'h8000 | 16'h2AD2, 16, 4'h0, 12'hFFF, "R2");
      frame(16'h7FFF, 16, 4'hA, 12'h555, "R3");
      frame(16'hFFFF, 10, 4'h5, 12'h0F0, "R5");
      frame(16'h9249, 20, 4'hF, 12'h800, "R6");
      frame(16'h8001, 16, 4'h1, 12'h123, "R9");
      frame(16'h0000, 16, 4'h2, 12'h456, "R9");
      frame(16'h8000, 9,  4'h4, 12'h789, "R9");
      frame(16'h8000, 16, 4'h6, 12'hFED, "R9");
      frame(16'hFFFF, 16, 4'hC, 12'h3C3, "R2");

      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      model = '0;
      push(0, 16'h0000, "R1");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule